// File: doc/BRIEF.md
# Write-Only Two-Wire Command Receiver

This block is the receiving end of a two-wire clock/data serial bus in the I2C family. A fast system clock oversamples both lines. Each line passes through a synchronizer and a stability filter. The block then finds the START and STOP conditions and takes in a one-byte device address followed by any number of command bytes.

The device accepts only writes. It acknowledges an address only when all of the following hold:

- the three upper bits match a fixed prefix;
- the four lower bits equal a strap input;
- the direction bit is zero;
- the programming-busy input is low.

A refused transfer is skipped until the next START or STOP. Every command byte that is taken is acknowledged and appears on a parallel output for one cycle. A STOP that closes a transfer carrying at least one command byte raises a one-cycle completion pulse.

The data line is open-drain. The block therefore provides only an enable that pulls the line low.

Top module: `wr_only_serial_rx`

## Requirements
- R1: After reset, `dat_pull_o`, `rx_valid_o` and `frame_done_o` are all low.
- R2: An address byte sent MSB first as `110` + strap (4 bits) + `0` is acknowledged: the data line is held low for the whole high phase of the ninth clock pulse.
- R3: An address whose upper three bits are not `110` is not acknowledged. All following bytes up to the next START or STOP are neither acknowledged nor presented.
- R4: An address whose four device bits differ from `dev_strap_i` is not acknowledged.
- R5: An address byte with direction bit (bit 0) equal to 1 is not acknowledged.
- R6: While `prog_busy_i` is high at the end of the address byte, the address is not acknowledged.
- R7: Every command byte after an acknowledged address is acknowledged. Its value, assembled MSB first, appears on `rx_byte_o` during a single-cycle `rx_valid_o` pulse.
- R8: A STOP ends the transfer. `frame_done_o` pulses for one cycle only if at least one command byte was received since the last START.
- R9: A START seen in the middle of a byte discards the partial byte and restarts address reception.
- R10: A pulse on either line that is shorter than `FILT_LEN` system clocks is ignored.
- R11: The pull-low enable changes only in the cycle after a falling clock edge, or after a START or STOP. It is never active while the data bits of a byte are being clocked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst | input | 1 | Synchronous active-high reset |
| bus_clk_i | input | 1 | Serial clock line as seen at the pad |
| bus_dat_i | input | 1 | Serial data line as seen at the pad |
| dev_strap_i | input | 4 | Device field that the low address bits are compared against |
| prog_busy_i | input | 1 | High while programming; blocks address acknowledge |
| dat_pull_o | output | 1 | When high, the pad pulls the data line low |
| rx_byte_o | output | 8 | Last received command byte |
| rx_valid_o | output | 1 | One-cycle strobe for `rx_byte_o` |
| frame_done_o | output | 1 | One-cycle pulse at a STOP that follows received data |

## Verification
The assertions assume a well-formed bus. The data line changes only while the clock is low, except for START and STOP. Every level is held far longer than the synchronizer and filter delay. No START or STOP falls inside an acknowledge pulse.

The bench drives the bus in quarter-bit steps of 16 system clocks and models the wired-AND data line. The only deliberate violation it applies is a one-cycle glitch on the data line, and that glitch is shorter than the filter window.

// File: rtl/wsr_pkg.sv
package wsr_pkg;
    localparam int ADDR_W  = 7;
    localparam int PFX_W   = 3;
    localparam int STRAP_W = ADDR_W - PFX_W;
    localparam logic [PFX_W-1:0] ADDR_PREFIX = 3'b110;
    localparam int BYTE_W  = 8;
    localparam int CNT_W   = $clog2(BYTE_W + 1);

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ADDR,
        ST_DATA,
        ST_SKIP
    } rx_state_e;

    typedef struct packed {
        logic clk_rise;
        logic clk_fall;
        logic start;
        logic stop;
        logic dat;
    } bus_evt_t;

    function automatic logic addr_hit(input logic [BYTE_W-1:0] b,
                                      input logic [STRAP_W-1:0] strap);
        return (b[BYTE_W-1 -: PFX_W] == ADDR_PREFIX) &&
               (b[STRAP_W:1] == strap) && (b[0] == 1'b0);
    endfunction
endpackage

// File: rtl/wsr_line_filter.sv
module wsr_line_filter #(
    parameter int SYNC_STAGES = 2,
    parameter int FILT_LEN    = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic raw_i,
    output logic clean_o
);
    localparam int FC_W = $clog2(FILT_LEN + 1);

    logic [SYNC_STAGES-1:0] sync_q;
    logic [FC_W-1:0]        run_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_q  <= '1;
            run_q   <= '0;
            clean_o <= 1'b1;
        end else begin
            sync_q <= {sync_q[SYNC_STAGES-2:0], raw_i};
            if (sync_q[SYNC_STAGES-1] == clean_o) begin
                run_q <= '0;
            end else if (run_q == FC_W'(FILT_LEN - 1)) begin
                clean_o <= sync_q[SYNC_STAGES-1];
                run_q   <= '0;
            end else begin
                run_q <= run_q + 1'b1;
            end
        end
    end
endmodule

// File: rtl/wsr_evt_detect.sv
module wsr_evt_detect
    import wsr_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     clk_f_i,
    input  logic     dat_f_i,
    output bus_evt_t evt_o
);
    logic clk_q, dat_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            clk_q <= 1'b1;
            dat_q <= 1'b1;
            evt_o <= '0;
        end else begin
            clk_q          <= clk_f_i;
            dat_q          <= dat_f_i;
            evt_o.clk_rise <= clk_f_i & ~clk_q;
            evt_o.clk_fall <= ~clk_f_i & clk_q;
            evt_o.start    <= clk_f_i & clk_q & dat_q & ~dat_f_i;
            evt_o.stop     <= clk_f_i & clk_q & ~dat_q & dat_f_i;
            evt_o.dat      <= dat_f_i;
        end
    end
endmodule

// File: rtl/wsr_engine.sv
module wsr_engine
    import wsr_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  bus_evt_t           evt_i,
    input  logic [STRAP_W-1:0] strap_i,
    input  logic               busy_i,
    output logic               pull_o,
    output logic [BYTE_W-1:0]  byte_o,
    output logic               valid_o,
    output logic               done_o
);
    rx_state_e         st_q;
    logic [BYTE_W-1:0] shift_q;
    logic [CNT_W-1:0]  nbits_q;
    logic              ack_phase_q, acked_q, got_data_q;
    logic              addr_ok;

    always_comb addr_ok = addr_hit(shift_q, strap_i) && !busy_i;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q        <= ST_IDLE;
            shift_q     <= '0;
            nbits_q     <= '0;
            ack_phase_q <= 1'b0;
            acked_q     <= 1'b0;
            got_data_q  <= 1'b0;
            pull_o      <= 1'b0;
            byte_o      <= '0;
            valid_o     <= 1'b0;
            done_o      <= 1'b0;
        end else begin
            valid_o <= 1'b0;
            done_o  <= 1'b0;
            if (evt_i.start) begin
                st_q        <= ST_ADDR;
                nbits_q     <= '0;
                ack_phase_q <= 1'b0;
                pull_o      <= 1'b0;
                got_data_q  <= 1'b0;
            end else if (evt_i.stop) begin
                done_o      <= (st_q == ST_DATA) && got_data_q;
                st_q        <= ST_IDLE;
                nbits_q     <= '0;
                ack_phase_q <= 1'b0;
                pull_o      <= 1'b0;
                got_data_q  <= 1'b0;
            end else if (st_q == ST_ADDR || st_q == ST_DATA) begin
                if (evt_i.clk_rise && !ack_phase_q &&
                    nbits_q < CNT_W'(BYTE_W)) begin
                    shift_q <= {shift_q[BYTE_W-2:0], evt_i.dat};
                    nbits_q <= nbits_q + 1'b1;
                end else if (evt_i.clk_fall && !ack_phase_q &&
                             nbits_q == CNT_W'(BYTE_W)) begin
                    ack_phase_q <= 1'b1;
                    if (st_q == ST_ADDR) begin
                        acked_q <= addr_ok;
                        pull_o  <= addr_ok;
                    end else begin
                        acked_q    <= 1'b1;
                        pull_o     <= 1'b1;
                        byte_o     <= shift_q;
                        valid_o    <= 1'b1;
                        got_data_q <= 1'b1;
                    end
                end else if (evt_i.clk_fall && ack_phase_q) begin
                    ack_phase_q <= 1'b0;
                    pull_o      <= 1'b0;
                    nbits_q     <= '0;
                    st_q        <= acked_q ? ST_DATA : ST_SKIP;
                end
            end
        end
    end
endmodule

// File: rtl/wr_only_serial_rx.sv
module wr_only_serial_rx
    import wsr_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int FILT_LEN    = 3
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               bus_clk_i,
    input  logic               bus_dat_i,
    input  logic [STRAP_W-1:0] dev_strap_i,
    input  logic               prog_busy_i,
    output logic               dat_pull_o,
    output logic [BYTE_W-1:0]  rx_byte_o,
    output logic               rx_valid_o,
    output logic               frame_done_o
);
    logic [1:0] line_raw;
    logic [1:0] line_clean;
    bus_evt_t   evt;

    assign line_raw = {bus_clk_i, bus_dat_i};

    for (genvar g = 0; g < 2; g++) begin : g_line
        wsr_line_filter #(
            .SYNC_STAGES(SYNC_STAGES),
            .FILT_LEN   (FILT_LEN)
        ) filt_i (
            .clk    (clk),
            .rst    (rst),
            .raw_i  (line_raw[g]),
            .clean_o(line_clean[g])
        );
    end

    wsr_evt_detect det_i (
        .clk    (clk),
        .rst    (rst),
        .clk_f_i(line_clean[1]),
        .dat_f_i(line_clean[0]),
        .evt_o  (evt)
    );

    wsr_engine eng_i (
        .clk    (clk),
        .rst    (rst),
        .evt_i  (evt),
        .strap_i(dev_strap_i),
        .busy_i (prog_busy_i),
        .pull_o (dat_pull_o),
        .byte_o (rx_byte_o),
        .valid_o(rx_valid_o),
        .done_o (frame_done_o)
    );
endmodule

// File: rtl/wsr_checker.sv
module wsr_checker (
    input logic clk,
    input logic rst,
    input logic clk_fall,
    input logic start_det,
    input logic stop_det,
    input logic pull,
    input logic valid,
    input logic done
);
    // R11: pull-low enable only rises right after a falling clock edge
    a_r11_pull_rise_on_fall: assert property (@(posedge clk) disable iff (rst)
        $rose(pull) |-> $past(clk_fall));
    // R11: pull-low release follows a falling edge, START or STOP
    a_r11_pull_fall_on_evt: assert property (@(posedge clk) disable iff (rst)
        $fell(pull) |-> $past(clk_fall || start_det || stop_det));
    // R9: a START always releases the data line
    a_r9_start_releases: assert property (@(posedge clk) disable iff (rst)
        start_det |=> !pull);
    // R7: byte strobe lasts one cycle
    a_r7_valid_pulse: assert property (@(posedge clk) disable iff (rst)
        valid |=> !valid);
    // R8: frame completion lasts one cycle
    a_r8_done_pulse: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);
    // R8: completion never coincides with a byte strobe
    a_r8_done_not_valid: assert property (@(posedge clk) disable iff (rst)
        !(done && valid));
endmodule

bind wr_only_serial_rx wsr_checker chk_i (
    .clk      (clk),
    .rst      (rst),
    .clk_fall (evt.clk_fall),
    .start_det(evt.start),
    .stop_det (evt.stop),
    .pull     (dat_pull_o),
    .valid    (rx_valid_o),
    .done     (frame_done_o)
);

// File: tb/wr_only_serial_rx_tb.sv
module wr_only_serial_rx_tb_top;
    localparam int Q = 16;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       m_clk = 1'b1, m_dat = 1'b1;
    logic [3:0] strap = 4'b1010;
    logic       busy = 1'b0;
    logic       pull, valid, done;
    logic [7:0] rbyte;
    wire        bus_dat = m_dat & ~pull;

    int checks = 0, errors = 0, done_seen = 0;
    logic [7:0] exp_q[$];
    string      cur_req = "R7";

    always #4 clk = ~clk;

    wr_only_serial_rx dut_i (
        .clk(clk), .rst(rst), .bus_clk_i(m_clk), .bus_dat_i(bus_dat),
        .dev_strap_i(strap), .prog_busy_i(busy), .dat_pull_o(pull),
        .rx_byte_o(rbyte), .rx_valid_o(valid), .frame_done_o(done));

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // monitor: scoreboard pops and compares
    always @(negedge clk) begin
        if (!rst && valid) begin
            checks++;
            if (exp_q.size() == 0) begin
                errors++;
                $display("FAIL %s actual=%0h expected=none", cur_req, rbyte);
            end else begin
                logic [7:0] e;
                e = exp_q.pop_front();
                if (rbyte !== e) begin
                    errors++;
                    $display("FAIL %s actual=%0h expected=%0h", cur_req, rbyte, e);
                end
            end
        end
        if (!rst && done) done_seen++;
    end

    task automatic wq(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        m_dat = 1'b1; wq(Q);
        m_clk = 1'b1; wq(Q);
        m_dat = 1'b0; wq(Q);
        m_clk = 1'b0; wq(Q);
    endtask

    task automatic bus_stop();
        m_dat = 1'b0; wq(Q);
        m_clk = 1'b1; wq(Q);
        m_dat = 1'b1; wq(2*Q);
    endtask

    task automatic send_bits(input logic [7:0] b, input int nb, input bit glitch);
        for (int i = 7; i > 7 - nb; i--) begin
            m_dat = b[i]; wq(Q);
            m_clk = 1'b1; wq(Q);
            if (glitch && i == 7) begin
                m_dat = ~b[i]; wq(1);
                m_dat = b[i];  wq(Q - 1);
            end else begin
                // R11: no pull while data bits are clocked
                if (i == 0) chk("R11", pull, 1'b0);
                wq(Q);
            end
            m_clk = 1'b0; wq(Q);
        end
    endtask

    task automatic send_byte(input logic [7:0] b, input bit glitch, output bit ack);
        send_bits(b, 8, glitch);
        m_dat = 1'b1; wq(Q);
        m_clk = 1'b1; wq(Q);
        ack = !bus_dat;
        wq(Q);
        ack = ack & !bus_dat;
        m_clk = 1'b0; wq(Q);
    endtask

    task automatic data_byte(input logic [7:0] b, input bit glitch);
        bit a;
        exp_q.push_back(b);
        send_byte(b, glitch, a);
        chk("R7", a, 1'b1);
    endtask

    initial begin
        bit a;
        int d0;
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R1", {pull, valid, done}, 3'b000);

        // R2 + R7 + R8
        bus_start(); send_byte(8'hD4, 0, a); chk("R2", a, 1'b1);
        data_byte(8'h3C, 0); data_byte(8'hA5, 0);
        bus_stop(); chk("R8", done_seen, 1);

        // R8: address-only transfer gives no completion pulse
        bus_start(); send_byte(8'hD4, 0, a); chk("R2", a, 1'b1);
        bus_stop(); chk("R8", done_seen, 1);

        // R3: wrong prefix, following byte skipped
        cur_req = "R3";
        bus_start(); send_byte(8'h94, 0, a); chk("R3", a, 1'b0);
        send_byte(8'h55, 0, a); chk("R3", a, 1'b0);
        bus_stop(); chk("R3", done_seen, 1);

        // R4: strap mismatch
        bus_start(); send_byte(8'hCA, 0, a); chk("R4", a, 1'b0); bus_stop();
        // R5: read direction
        bus_start(); send_byte(8'hD5, 0, a); chk("R5", a, 1'b0); bus_stop();
        // R6: programming busy
        busy = 1'b1;
        bus_start(); send_byte(8'hD4, 0, a); chk("R6", a, 1'b0); bus_stop();
        busy = 1'b0;
        chk("R6", done_seen, 1);

        // R9: repeated START mid-byte
        cur_req = "R9";
        bus_start(); send_byte(8'hD4, 0, a); chk("R9", a, 1'b1);
        send_bits(8'hE0, 3, 0);
        bus_start(); send_byte(8'hD4, 0, a); chk("R9", a, 1'b1);
        data_byte(8'h81, 0);
        bus_stop(); chk("R9", done_seen, 2);

        // R10: short glitch on data while clock high
        cur_req = "R10";
        d0 = done_seen;
        bus_start(); send_byte(8'hD4, 0, a); chk("R10", a, 1'b1);
        data_byte(8'hF0, 1);
        chk("R10", done_seen, d0);
        bus_stop(); chk("R10", done_seen, d0 + 1);

        chk("R7", exp_q.size(), 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog R1 actual=hung expected=finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule